// File: doc/BRIEF.md
# Configurable Arithmetic Processing Element

A single 32-bit compute element meant to be tiled into a linear array of such elements. Static configuration inputs choose its function: an ALU operation, a shift, a signed compare or an unsigned 16x16 multiply. They also choose where each of its two operands comes from: one of four unit-level inputs, the result of either of the two elements before it, a constant from a local eight-entry bank, or zero.

A per-configuration mode bit controls how the result leaves the element. In pass-through mode the element is purely combinational, so a chain of elements settles within one clock cycle. In staged mode the result and the compare flag come from a register, so the element forms one pipeline stage. That register loads only on edges where the stage enable is high. The constant bank has its own synchronous write port.

Top module: `cfg_pe`

## Requirements
- R1: While `rst_ni` is low, and after it rises until the first enabled capture, the staged result register and staged flag are zero. Every constant bank entry is zero after reset.
- R2: Operand source codes (3 bits): 0 to 3 select unit input 0 to 3, where unit input k is `unit_in_i[32k+31:32k]`. Code 4 selects `prev1_i`, 5 selects `prev2_i`, 6 selects the constant addressed by that operand's constant index, and 7 gives zero.
- R3: Opcode 0 gives A+B, 1 gives A-B, 2 gives 0-A, 3 gives A AND B, 4 gives A OR B and 5 gives A XOR B. All arithmetic wraps modulo 2^32, and the flag is 0 for all of these.
- R4: Opcode 6 is a signed compare. When A < B as two's complement numbers, the flag is 1 and the result word is 1. Otherwise both are 0. The flag is 0 for every other opcode.
- R5: Opcode 7 shifts A left logically, 8 shifts it right logically and 9 shifts it right arithmetically. The shift amount is B[4:0], and the upper bits of B are ignored.
- R6: Opcode 10 gives the unsigned 32-bit product of A[15:0] and B[15:0].
- R7: With `reg_mode_i` low, `res_o` and `flag_o` follow operand and configuration changes in the same cycle, with no clock edge needed.
- R8: With `reg_mode_i` high, `res_o` and `flag_o` show the values captured at the last rising edge with `stage_en_i` high. Edges with `stage_en_i` low leave them unchanged, and so do input changes between edges.
- R9: A constant write (`kwr_en_i` high) takes effect at the rising edge. A read of that entry before the edge returns the old value, and all other entries are left unchanged.
- R10: Opcodes 11 to 15 give a result of zero and a flag of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| op_i | input | 4 | Operation code |
| src_a_i | input | 3 | Operand A source code |
| src_b_i | input | 3 | Operand B source code |
| kidx_a_i | input | 3 | Constant index for operand A |
| kidx_b_i | input | 3 | Constant index for operand B |
| reg_mode_i | input | 1 | 1 = staged output, 0 = pass-through |
| stage_en_i | input | 1 | Output register load enable |
| unit_in_i | input | 128 | Four packed unit input operands |
| prev1_i | input | 32 | Result of the preceding element |
| prev2_i | input | 32 | Result of the element two positions back |
| kwr_en_i | input | 1 | Constant bank write enable |
| kwr_idx_i | input | 3 | Constant bank write index |
| kwr_data_i | input | 32 | Constant bank write data |
| res_o | output | 32 | Result word |
| flag_o | output | 1 | Compare flag |

## Verification
The compare is tested with operands that straddle the sign boundary, such as 0x80000000 against 0x7FFFFFFF. An unsigned comparator would report these inverted. Shifts use an amount of 33 and a 31-bit arithmetic shift: a design that used the full B, or that dropped sign extension, would return zero or a bare 1 instead of the expected value. The multiply is fed operands with dirty upper halves, which exposes a product formed from all 32 bits. The bench reads a constant entry in the same cycle it is written, to catch a bank that bypasses the write to the read port. It also changes inputs between edges while in staged mode, and holds `stage_en_i` low across an edge, to catch an output that leaks through or reloads without the enable.

// File: rtl/cfg_pe_pkg.sv
package cfg_pe_pkg;
  typedef enum logic [3:0] {
    OP_ADD = 4'd0,
    OP_SUB = 4'd1,
    OP_NEG = 4'd2,
    OP_AND = 4'd3,
    OP_OR  = 4'd4,
    OP_XOR = 4'd5,
    OP_SLT = 4'd6,
    OP_SLL = 4'd7,
    OP_SRL = 4'd8,
    OP_SRA = 4'd9,
    OP_MUL = 4'd10
  } pe_op_e;
endpackage

// File: rtl/cfg_pe_opsel.sv
module cfg_pe_opsel #(
  parameter int W     = 32,
  parameter int N_IN  = 4,
  parameter int SRC_W = $clog2(N_IN + 4)
) (
  input  logic [SRC_W-1:0]  sel_i,
  input  logic [N_IN*W-1:0] unit_in_i,
  input  logic [W-1:0]      prev1_i,
  input  logic [W-1:0]      prev2_i,
  input  logic [W-1:0]      kval_i,
  output logic [W-1:0]      opnd_o
);
  always_comb begin
    opnd_o = '0;
    for (int i = 0; i < N_IN; i++) begin
      if (sel_i == SRC_W'(i)) opnd_o = unit_in_i[i*W +: W];
    end
    if (sel_i == SRC_W'(N_IN))     opnd_o = prev1_i;
    if (sel_i == SRC_W'(N_IN + 1)) opnd_o = prev2_i;
    if (sel_i == SRC_W'(N_IN + 2)) opnd_o = kval_i;
  end
endmodule

// File: rtl/cfg_pe_kbank.sv
module cfg_pe_kbank #(
  parameter int W      = 32,
  parameter int N_K    = 8,
  parameter int KIDX_W = $clog2(N_K)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [KIDX_W-1:0] widx_i,
  input  logic [W-1:0]      wdata_i,
  input  logic [KIDX_W-1:0] ridx_a_i,
  input  logic [KIDX_W-1:0] ridx_b_i,
  output logic [W-1:0]      rdata_a_o,
  output logic [W-1:0]      rdata_b_o
);
  logic [W-1:0] mem_q [N_K];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < N_K; k++) mem_q[k] <= '0;
    end else if (we_i) begin
      mem_q[widx_i] <= wdata_i;
    end
  end

  // reads see the pre-write value in the write cycle
  assign rdata_a_o = mem_q[ridx_a_i];
  assign rdata_b_o = mem_q[ridx_b_i];
endmodule

// File: rtl/cfg_pe_fu.sv
module cfg_pe_fu
  import cfg_pe_pkg::*;
#(
  parameter int W    = 32,
  parameter int SH_W = $clog2(W),
  parameter int HW   = W / 2
) (
  input  logic [3:0]   op_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] res_o,
  output logic         flag_o
);
  logic [SH_W-1:0] sh_amt;
  logic            lt;

  assign sh_amt = b_i[SH_W-1:0];
  assign lt     = $signed(a_i) < $signed(b_i);

  always_comb begin
    res_o  = '0;
    flag_o = 1'b0;
    case (op_i)
      OP_ADD: res_o = a_i + b_i;
      OP_SUB: res_o = a_i - b_i;
      OP_NEG: res_o = '0 - a_i;
      OP_AND: res_o = a_i & b_i;
      OP_OR:  res_o = a_i | b_i;
      OP_XOR: res_o = a_i ^ b_i;
      OP_SLT: begin
        flag_o = lt;
        res_o  = W'(lt);
      end
      OP_SLL: res_o = a_i << sh_amt;
      OP_SRL: res_o = a_i >> sh_amt;
      OP_SRA: res_o = W'($signed(a_i) >>> sh_amt);
      OP_MUL: res_o = W'(a_i[HW-1:0]) * W'(b_i[HW-1:0]);
      default: ;
    endcase
  end
endmodule

// File: rtl/cfg_pe.sv
module cfg_pe #(
  parameter int W      = 32,
  parameter int N_IN   = 4,
  parameter int N_K    = 8,
  parameter int SRC_W  = $clog2(N_IN + 4),
  parameter int KIDX_W = $clog2(N_K)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [3:0]        op_i,
  input  logic [SRC_W-1:0]  src_a_i,
  input  logic [SRC_W-1:0]  src_b_i,
  input  logic [KIDX_W-1:0] kidx_a_i,
  input  logic [KIDX_W-1:0] kidx_b_i,
  input  logic              reg_mode_i,
  input  logic              stage_en_i,
  input  logic [N_IN*W-1:0] unit_in_i,
  input  logic [W-1:0]      prev1_i,
  input  logic [W-1:0]      prev2_i,
  input  logic              kwr_en_i,
  input  logic [KIDX_W-1:0] kwr_idx_i,
  input  logic [W-1:0]      kwr_data_i,
  output logic [W-1:0]      res_o,
  output logic              flag_o
);
  logic [W-1:0] kval_a, kval_b, opnd_a, opnd_b, fu_res, res_q;
  logic         fu_flag, flag_q;

  cfg_pe_kbank #(.W(W), .N_K(N_K)) i_kbank (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (kwr_en_i),
    .widx_i    (kwr_idx_i),
    .wdata_i   (kwr_data_i),
    .ridx_a_i  (kidx_a_i),
    .ridx_b_i  (kidx_b_i),
    .rdata_a_o (kval_a),
    .rdata_b_o (kval_b)
  );

  cfg_pe_opsel #(.W(W), .N_IN(N_IN)) i_sel_a (
    .sel_i     (src_a_i),
    .unit_in_i (unit_in_i),
    .prev1_i   (prev1_i),
    .prev2_i   (prev2_i),
    .kval_i    (kval_a),
    .opnd_o    (opnd_a)
  );

  cfg_pe_opsel #(.W(W), .N_IN(N_IN)) i_sel_b (
    .sel_i     (src_b_i),
    .unit_in_i (unit_in_i),
    .prev1_i   (prev1_i),
    .prev2_i   (prev2_i),
    .kval_i    (kval_b),
    .opnd_o    (opnd_b)
  );

  cfg_pe_fu #(.W(W)) i_fu (
    .op_i   (op_i),
    .a_i    (opnd_a),
    .b_i    (opnd_b),
    .res_o  (fu_res),
    .flag_o (fu_flag)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_q  <= '0;
      flag_q <= 1'b0;
    end else if (stage_en_i) begin
      res_q  <= fu_res;
      flag_q <= fu_flag;
    end
  end

  assign res_o  = reg_mode_i ? res_q  : fu_res;
  assign flag_o = reg_mode_i ? flag_q : fu_flag;
endmodule

// File: rtl/cfg_pe_chk.sv
module cfg_pe_chk #(
  parameter int W = 32
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic [3:0]   op_i,
  input logic         reg_mode_i,
  input logic         stage_en_i,
  input logic [W-1:0] res_o,
  input logic         flag_o,
  input logic [W-1:0] fu_res,
  input logic         fu_flag
);
  AST_REG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_mode_i && !stage_en_i) |=> (!reg_mode_i || ($stable(res_o) && $stable(flag_o)))); // R8
  AST_REG_CAPTURE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stage_en_i |=> (!reg_mode_i || (res_o == $past(fu_res) && flag_o == $past(fu_flag)))); // R8
  AST_COMB_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !reg_mode_i |-> (res_o == fu_res && flag_o == fu_flag)); // R7
  AST_FLAG_ONLY_CMP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i != 4'd6) |-> !fu_flag); // R4
  AST_FLAG_WORD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_o |-> (res_o == W'(1))); // R4
  AST_BAD_OP_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i > 4'd10) |-> (fu_res == '0 && !fu_flag)); // R10
endmodule

bind cfg_pe cfg_pe_chk #(.W(W)) i_cfg_pe_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .op_i       (op_i),
  .reg_mode_i (reg_mode_i),
  .stage_en_i (stage_en_i),
  .res_o      (res_o),
  .flag_o     (flag_o),
  .fu_res     (fu_res),
  .fu_flag    (fu_flag)
);

// File: tb/test_cfg_pe.sv
`timescale 1ns/1ps
module test_cfg_pe;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [3:0]  op_i = '0;
  logic [2:0]  src_a_i = 3'd7, src_b_i = 3'd7, kidx_a_i = '0, kidx_b_i = '0;
  logic        reg_mode_i = 1'b0, stage_en_i = 1'b0;
  logic [127:0] unit_in_i = '0;
  logic [31:0] prev1_i = '0, prev2_i = '0;
  logic        kwr_en_i = 1'b0;
  logic [2:0]  kwr_idx_i = '0;
  logic [31:0] kwr_data_i = '0;
  logic [31:0] res_o;
  logic        flag_o;

  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk_i = ~clk_i;

  cfg_pe i_cfg_pe (.*);

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic run_op(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b);
    unit_in_i[31:0]  = a;
    unit_in_i[63:32] = b;
    src_a_i = 3'd0;
    src_b_i = 3'd1;
    op_i = op;
    #1;
  endtask

  task automatic t_reset;
    reg_mode_i = 1'b1;
    #1;
    check("R1 staged result", res_o, 32'h0);
    check("R1 staged flag", {31'b0, flag_o}, 32'h0);
    reg_mode_i = 1'b0;
    op_i = 4'd0; src_a_i = 3'd6; src_b_i = 3'd6; kidx_a_i = 3'd3; kidx_b_i = 3'd7;
    #1;
    check("R1 constants zero", res_o, 32'h0);
  endtask

  task automatic t_sources;
    unit_in_i = {32'h4444_0004, 32'h3333_0003, 32'h2222_0002, 32'h1111_0001};
    prev1_i = 32'h5555_0005;
    prev2_i = 32'h6666_0006;
    op_i = 4'd0; src_b_i = 3'd7;
    src_a_i = 3'd0; #1; check("R2 unit0", res_o, 32'h1111_0001);
    src_a_i = 3'd2; #1; check("R2 unit2", res_o, 32'h3333_0003);
    src_a_i = 3'd3; #1; check("R2 unit3", res_o, 32'h4444_0004);
    src_a_i = 3'd4; #1; check("R2 prev1", res_o, 32'h5555_0005);
    src_a_i = 3'd5; #1; check("R2 prev2", res_o, 32'h6666_0006);
    src_a_i = 3'd7; src_b_i = 3'd1; #1; check("R2 zero A, unit1 B", res_o, 32'h2222_0002);
  endtask

  task automatic t_alu;
    run_op(4'd0, 32'hFFFF_FFFF, 32'h1); check("R3 add wrap", res_o, 32'h0);
    run_op(4'd0, 32'h1234, 32'h1111); check("R3 add", res_o, 32'h2345);
    run_op(4'd1, 32'h0, 32'h1); check("R3 sub wrap", res_o, 32'hFFFF_FFFF);
    run_op(4'd2, 32'h5, 32'h99); check("R3 neg", res_o, 32'hFFFF_FFFB);
    run_op(4'd2, 32'h0, 32'h99); check("R3 neg zero", res_o, 32'h0);
    run_op(4'd3, 32'hF0F0_FF00, 32'hFF00_0FF0); check("R3 and", res_o, 32'hF000_0F00);
    run_op(4'd4, 32'hF0F0_FF00, 32'hFF00_0FF0); check("R3 or", res_o, 32'hFFF0_FFF0);
    run_op(4'd5, 32'hF0F0_FF00, 32'hFF00_0FF0); check("R3 xor", res_o, 32'h0FF0_F0F0);
    check("R3 flag low", {31'b0, flag_o}, 32'h0);
  endtask

  task automatic t_cmp;
    run_op(4'd6, 32'hFFFF_FFFF, 32'h1);
    check("R4 -1<1 word", res_o, 32'h1); check("R4 -1<1 flag", {31'b0, flag_o}, 32'h1);
    run_op(4'd6, 32'h1, 32'hFFFF_FFFF);
    check("R4 1<-1 word", res_o, 32'h0); check("R4 1<-1 flag", {31'b0, flag_o}, 32'h0);
    run_op(4'd6, 32'h7, 32'h7); check("R4 equal", {31'b0, flag_o}, 32'h0);
    run_op(4'd6, 32'h8000_0000, 32'h7FFF_FFFF); check("R4 min<max", res_o, 32'h1);
  endtask

  task automatic t_shift;
    run_op(4'd7, 32'h8000_0003, 32'd33); check("R5 sll by 33->1", res_o, 32'h0000_0006);
    run_op(4'd8, 32'h8000_0000, 32'd31); check("R5 srl 31", res_o, 32'h1);
    run_op(4'd9, 32'h8000_0000, 32'd31); check("R5 sra 31", res_o, 32'hFFFF_FFFF);
    run_op(4'd9, 32'h4000_0000, 32'hFFFF_FFE2); check("R5 sra positive by 2", res_o, 32'h1000_0000);
  endtask

  task automatic t_mul;
    run_op(4'd10, 32'h1234_FFFF, 32'hABCD_FFFF); check("R6 mul max", res_o, 32'hFFFE_0001);
    run_op(4'd10, 32'hFFFF_0003, 32'h0001_0007); check("R6 mul small", res_o, 32'd21);
  endtask

  task automatic t_comb;
    reg_mode_i = 1'b0;
    run_op(4'd0, 32'd10, 32'd20); check("R7 first", res_o, 32'd30);
    unit_in_i[31:0] = 32'd100; #0.5;
    check("R7 same-cycle update", res_o, 32'd120);
  endtask

  task automatic t_staged;
    @(negedge clk_i);
    reg_mode_i = 1'b1;
    run_op(4'd0, 32'd10, 32'd20);
    check("R8 before capture", res_o, 32'h0);
    stage_en_i = 1'b1;
    @(posedge clk_i); #1;
    check("R8 captured", res_o, 32'd30);
    @(negedge clk_i);
    stage_en_i = 1'b0;
    unit_in_i[31:0] = 32'd500; #1;
    check("R8 no leak between edges", res_o, 32'd30);
    @(posedge clk_i); #1;
    check("R8 hold without enable", res_o, 32'd30);
    @(negedge clk_i);
    run_op(4'd6, 32'hFFFF_FFF0, 32'h2);
    stage_en_i = 1'b1;
    @(posedge clk_i); #1;
    check("R8 staged compare word", res_o, 32'h1);
    check("R8 staged compare flag", {31'b0, flag_o}, 32'h1);
    @(negedge clk_i);
    stage_en_i = 1'b0;
    reg_mode_i = 1'b0;
  endtask

  task automatic t_kwrite;
    @(negedge clk_i);
    op_i = 4'd0; src_a_i = 3'd6; src_b_i = 3'd7; kidx_a_i = 3'd2;
    kwr_en_i = 1'b1; kwr_idx_i = 3'd2; kwr_data_i = 32'hCAFE_0001;
    #1;
    check("R9 old value before edge", res_o, 32'h0);
    @(posedge clk_i); #1;
    check("R9 new value after edge", res_o, 32'hCAFE_0001);
    @(negedge clk_i);
    kwr_idx_i = 3'd7; kwr_data_i = 32'h5;
    @(posedge clk_i); #1;
    kwr_en_i = 1'b0;
    src_a_i = 3'd7; src_b_i = 3'd6; kidx_b_i = 3'd7; #1;
    check("R9 entry 7 via B", res_o, 32'h5);
    kidx_b_i = 3'd3; #1;
    check("R9 entry 3 untouched", res_o, 32'h0);
    kidx_b_i = 3'd2; #1;
    check("R9 entry 2 kept", res_o, 32'hCAFE_0001);
  endtask

  task automatic t_badop;
    for (int k = 11; k < 16; k++) begin
      run_op(4'(k), 32'hFFFF_FFFF, 32'h8000_0001);
      check("R10 undefined op result", res_o, 32'h0);
      check("R10 undefined op flag", {31'b0, flag_o}, 32'h0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset;
    @(negedge clk_i);
    rst_ni = 1'b1;
    t_reset;
    t_sources;
    t_alu;
    t_cmp;
    t_shift;
    t_mul;
    t_comb;
    t_staged;
    t_kwrite;
    t_badop;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #100us;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule